// File: doc/BRIEF.md
# Coefficient Quantizer and Rescaler

This unit turns signed transform coefficients into quantized levels and turns levels back into coefficients. A 6-bit quantization parameter sets the step size. One sample enters per clock with a valid strobe, and one result leaves exactly one cycle later.

A mode input selects the direction, forward or inverse. A second input marks a sample as a DC term. DC terms use their own rounding and shift, and the inverse DC rule splits on the quantization parameter. For non-DC samples, a 2-bit position class picks the column of the internal scaling tables. The row of those tables is the quantization parameter modulo 6.

The block is meant to sit between a transform stage and an entropy coder or a reconstruction loop. It handles a stream of mixed forward and inverse work with no stall cycles.

Top module: `qscale_unit`

## Requirements
- R1: While reset is asserted, and right after it, `out_valid` is 0 and `out_data` is 0.
- R2: Each accepted sample (`in_valid`=1 at a rising edge) produces `out_valid`=1 on the next edge. Samples may be presented on consecutive cycles. With `in_valid`=0, `out_valid` is 0 one cycle later.
- R3: When `in_valid` is 0, `out_data` keeps its previous value, whatever the other inputs do.
- R4: Forward, non-DC (`in_inverse`=0, `in_dc`=0): with s = 15 + floor(QP/6) and f = floor(2^s/3), the level magnitude is (|x|·MF + f) >> s. The level takes the sign of the input.
- R5: Forward DC (`in_inverse`=0, `in_dc`=1): the level magnitude is (|x|·MF + 2f) >> (s+1), with the sign of the input. The position class is ignored and class 0 is used.
- R6: Inverse, non-DC (`in_inverse`=1, `in_dc`=0): the result is z·V·2^floor(QP/6).
- R7: Inverse DC with QP ≥ 12: the result is z·V·2^(floor(QP/6)−2). The position class is ignored and class 0 is used.
- R8: Inverse DC with QP < 12: the result is (z·V + 2^(1−floor(QP/6))) shifted right arithmetically by 2−floor(QP/6), so negative values round toward minus infinity. Class 0 is used.
- R9: Position class encoding: 0 means both indices even, 1 means both indices odd, 2 and 3 mean mixed. For rows QP mod 6 = 0..5 the tables are:
  - MF, class 0: 13107, 11916, 10082, 9362, 8192, 7282
  - MF, class 1: 5243, 4660, 4194, 3647, 3355, 2893
  - MF, mixed: 8066, 7490, 6554, 5825, 5243, 4559
  - V, class 0: 10, 11, 13, 14, 16, 18
  - V, class 1: 16, 18, 20, 23, 25, 29
  - V, mixed: 13, 14, 16, 18, 20, 23
- R10: A zero input gives a zero result in every mode, with no negative artifact.
- R11: A QP value above 51 is treated as 51.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample strobe |
| in_inverse | input | 1 | 0 = quantize, 1 = rescale |
| in_dc | input | 1 | Sample is a DC term |
| in_pos | input | 2 | Position class (0 even/even, 1 odd/odd, 2/3 mixed) |
| in_qp | input | QPW (6) | Quantization parameter |
| in_data | input | DW (16) | Signed coefficient or level |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_data | output | OW (32) | Signed result |

## Verification
Several rules are checked by the assertions on every cycle:
- the one-cycle valid latency;
- the hold of the result while idle;
- that a non-negative forward input never gives a negative level;
- that a zero input gives a zero result;
- that an out-of-range QP is folded onto row 3 of shift group 8.

The exact arithmetic can only be shown by the bench's vectors:
- the rounding offsets;
- the table entries;
- the two inverse DC branches, including the floor rounding of negative values;
- that the position class is ignored for DC terms.

// File: rtl/qscale_pkg.sv
package qscale_pkg;

  localparam int QP_MAX = 51;
  localparam int ACC    = 48;
  localparam int QB0    = 15;

  // MF table: row = QP mod 6, class 0 even/even, 1 odd/odd, else mixed
  function automatic logic [13:0] mf_lookup(input logic [2:0] row, input logic [1:0] cls);
    logic [13:0] r;
    case (cls)
      2'd0: case (row)
        3'd0: r = 14'd13107; 3'd1: r = 14'd11916; 3'd2: r = 14'd10082;
        3'd3: r = 14'd9362;  3'd4: r = 14'd8192;  default: r = 14'd7282;
      endcase
      2'd1: case (row)
        3'd0: r = 14'd5243;  3'd1: r = 14'd4660;  3'd2: r = 14'd4194;
        3'd3: r = 14'd3647;  3'd4: r = 14'd3355;  default: r = 14'd2893;
      endcase
      default: case (row)
        3'd0: r = 14'd8066;  3'd1: r = 14'd7490;  3'd2: r = 14'd6554;
        3'd3: r = 14'd5825;  3'd4: r = 14'd5243;  default: r = 14'd4559;
      endcase
    endcase
    return r;
  endfunction

  // V table with the same indexing
  function automatic logic [4:0] v_lookup(input logic [2:0] row, input logic [1:0] cls);
    logic [4:0] r;
    case (cls)
      2'd0: case (row)
        3'd0: r = 5'd10; 3'd1: r = 5'd11; 3'd2: r = 5'd13;
        3'd3: r = 5'd14; 3'd4: r = 5'd16; default: r = 5'd18;
      endcase
      2'd1: case (row)
        3'd0: r = 5'd16; 3'd1: r = 5'd18; 3'd2: r = 5'd20;
        3'd3: r = 5'd23; 3'd4: r = 5'd25; default: r = 5'd29;
      endcase
      default: case (row)
        3'd0: r = 5'd13; 3'd1: r = 5'd14; 3'd2: r = 5'd16;
        3'd3: r = 5'd18; 3'd4: r = 5'd20; default: r = 5'd23;
      endcase
    endcase
    return r;
  endfunction

  // floor(2^k / 3): alternating ones at bit k-2, k-4, ... down to bit 0 or 1
  function automatic logic [ACC-1:0] third_of_pow2(input logic [5:0] k);
    logic [ACC-1:0] r;
    r = '0;
    for (int j = 0; j < ACC; j++) begin
      if ((j + 2 <= int'(k)) && (((int'(k) - 2 - j) % 2) == 0)) r[j] = 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/qs_qp_decode.sv
module qs_qp_decode import qscale_pkg::*; #(
  parameter int QPW = 6
) (
  input  logic [QPW-1:0] qp_in,
  output logic [3:0]     qdiv,
  output logic [2:0]     qmod
);
  int qpc;

  always_comb begin
    qpc  = (int'(qp_in) > QP_MAX) ? QP_MAX : int'(qp_in);
    qdiv = 4'(qpc / 6);
    qmod = 3'(qpc % 6);
  end
endmodule

// File: rtl/qs_fwd_path.sv
module qs_fwd_path import qscale_pkg::*; #(
  parameter int DW = 16,
  parameter int OW = 32
) (
  input  logic signed [DW-1:0] coef,
  input  logic                 dc,
  input  logic [1:0]           pos,
  input  logic [3:0]           qdiv,
  input  logic [2:0]           qmod,
  output logic signed [OW-1:0] level
);
  localparam int MW = DW + 1;

  logic                 neg;
  logic signed [MW-1:0] cx;
  logic [MW-1:0]        mag;
  logic [13:0]          mf;
  logic [5:0]           qbits;
  logic [5:0]           sh;
  logic [ACC-1:0]       f;
  logic [ACC-1:0]       rnd;
  logic [ACC-1:0]       prod;
  logic [ACC-1:0]       q;

  always_comb begin
    neg   = coef[DW-1];
    cx    = MW'(coef);
    mag   = neg ? unsigned'(-cx) : unsigned'(cx);
    mf    = mf_lookup(qmod, dc ? 2'd0 : pos);
    qbits = 6'(QB0) + 6'(qdiv);
    sh    = qbits + 6'(dc);
    f     = third_of_pow2(qbits);
    rnd   = dc ? (f << 1) : f;
    prod  = ACC'(mag) * ACC'(mf) + rnd;
    q     = prod >> sh;
    level = neg ? -OW'(q) : OW'(q);
  end
endmodule

// File: rtl/qs_inv_path.sv
module qs_inv_path import qscale_pkg::*; #(
  parameter int DW = 16,
  parameter int OW = 32
) (
  input  logic signed [DW-1:0] lvl,
  input  logic                 dc,
  input  logic [1:0]           pos,
  input  logic [3:0]           qdiv,
  input  logic [2:0]           qmod,
  output logic signed [OW-1:0] coef
);
  logic [4:0]            v;
  logic signed [ACC-1:0] zx;
  logic signed [ACC-1:0] vs;
  logic signed [ACC-1:0] p;
  logic signed [ACC-1:0] r;
  logic [3:0]            rsh;

  always_comb begin
    v   = v_lookup(qmod, dc ? 2'd0 : pos);
    zx  = ACC'(lvl);
    vs  = signed'(ACC'(v));
    p   = zx * vs;
    rsh = 4'd2 - qdiv;
    if (!dc)             r = p <<< qdiv;
    else if (qdiv >= 4'd2) r = p <<< (qdiv - 4'd2);
    else                 r = (p + (ACC'(1) << (4'd1 - qdiv))) >>> rsh;
    coef = OW'(r);
  end
endmodule

// File: rtl/qscale_unit.sv
module qscale_unit import qscale_pkg::*; #(
  parameter int DW  = 16,
  parameter int OW  = 32,
  parameter int QPW = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_inverse,
  input  logic                 in_dc,
  input  logic [1:0]           in_pos,
  input  logic [QPW-1:0]       in_qp,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_data
);
  logic [3:0]           qdiv;
  logic [2:0]           qmod;
  logic signed [OW-1:0] fwd_level;
  logic signed [OW-1:0] inv_coef;

  // named events for the checks
  logic zero_in;
  logic fwd_nonneg_in;
  logic qp_over;
  assign zero_in       = in_valid && (in_data == '0);
  assign fwd_nonneg_in = in_valid && !in_inverse && !in_data[DW-1];
  assign qp_over       = int'(in_qp) > QP_MAX;

  qs_qp_decode #(.QPW(QPW)) u_dec (
    .qp_in(in_qp), .qdiv(qdiv), .qmod(qmod)
  );

  qs_fwd_path #(.DW(DW), .OW(OW)) u_fwd (
    .coef(in_data), .dc(in_dc), .pos(in_pos),
    .qdiv(qdiv), .qmod(qmod), .level(fwd_level)
  );

  qs_inv_path #(.DW(DW), .OW(OW)) u_inv (
    .lvl(in_data), .dc(in_dc), .pos(in_pos),
    .qdiv(qdiv), .qmod(qmod), .coef(inv_coef)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_inverse ? inv_coef : fwd_level;
    end
  end

  // R2
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  idle_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));
  // R4
  fwd_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_nonneg_in |=> !out_data[OW-1]);
  // R10
  zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_in |=> out_data == '0);
  // R11
  qp_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    qp_over |-> (qdiv == 4'd8 && qmod == 3'd3));
endmodule

// File: tb/test_qscale_unit.sv
module test_qscale_unit;
  typedef struct packed {
    logic               inv;
    logic               dc;
    logic [1:0]         pos;
    logic [5:0]         qp;
    logic signed [15:0] din;
    logic signed [31:0] exp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 2'd0, 6'd28, 16'sd100,   32'sd1},    // R4
    '{1'b0, 1'b0, 2'd0, 6'd28, -16'sd600,  -32'sd9},   // R4 sign
    '{1'b0, 1'b0, 2'd1, 6'd0,  16'sd50,    32'sd8},    // R9 class 1
    '{1'b0, 1'b0, 2'd2, 6'd51, 16'sd2000,  32'sd1},    // R9 mixed
    '{1'b0, 1'b1, 2'd1, 6'd28, -16'sd1000, -32'sd8},   // R5 class ignored
    '{1'b0, 1'b0, 2'd0, 6'd10, 16'sd0,     32'sd0},    // R10
    '{1'b1, 1'b0, 2'd0, 6'd28, -16'sd3,    -32'sd768}, // R6
    '{1'b1, 1'b0, 2'd1, 6'd7,  16'sd5,     32'sd180},  // R6
    '{1'b1, 1'b1, 2'd2, 6'd30, 16'sd7,     32'sd560},  // R7
    '{1'b1, 1'b1, 2'd1, 6'd12, -16'sd4,    -32'sd40},  // R7 boundary
    '{1'b1, 1'b1, 2'd3, 6'd3,  16'sd5,     32'sd18},   // R8
    '{1'b1, 1'b1, 2'd2, 6'd8,  -16'sd3,    -32'sd19},  // R8 negative
    '{1'b1, 1'b1, 2'd1, 6'd11, 16'sd3,     32'sd27},   // R8 boundary
    '{1'b0, 1'b0, 2'd2, 6'd63, 16'sd2000,  32'sd1},    // R11
    '{1'b0, 1'b1, 2'd0, 6'd20, 16'sd0,     32'sd0},    // R10 DC
    '{1'b1, 1'b1, 2'd0, 6'd2,  16'sd0,     32'sd0}     // R10 inverse DC
  };

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic               in_inverse = 1'b0;
  logic               in_dc = 1'b0;
  logic [1:0]         in_pos = 2'd0;
  logic [5:0]         in_qp = 6'd0;
  logic signed [15:0] in_data = 16'sd0;
  logic               out_valid;
  logic signed [31:0] out_data;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  qscale_unit i_qscale_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_inverse(in_inverse),
    .in_dc(in_dc), .in_pos(in_pos), .in_qp(in_qp), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  task automatic chk(input string tag, input logic signed [31:0] act,
                     input logic signed [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_valid   = 1'b1;
    in_inverse = v.inv;
    in_dc      = v.dc;
    in_pos     = v.pos;
    in_qp      = v.qp;
    in_data    = v.din;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: outputs during reset
    repeat (2) @(negedge clk);
    chk("R1 valid in reset", 32'(out_valid), 0);
    chk("R1 data in reset", out_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", 32'(out_valid), 0);

    // Vector walk, back to back (R2)
    for (int i = 0; i <= NV; i++) begin
      if (i < NV) drive(VEC[i]);
      else in_valid = 1'b0;
      @(negedge clk);
      if (i < NV) begin
        chk($sformatf("R2 valid vec%0d", i), 32'(out_valid), 1);
        chk($sformatf("vec%0d (R4..R11)", i), out_data, VEC[i].exp);
      end
    end
    chk("R2 valid drops", 32'(out_valid), 0);

    // R3: idle inputs change, result held
    drive(VEC[6]);
    @(negedge clk);
    chk("R6 setup", out_data, -32'sd768);
    in_valid = 1'b0;
    in_data = 16'sd1234;
    in_inverse = 1'b0;
    in_qp = 6'd40;
    repeat (3) @(negedge clk);
    chk("R3 data held", out_data, -32'sd768);
    chk("R3 valid low", 32'(out_valid), 0);

    // R1: reset mid-run clears result
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 data cleared", out_data, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: most negative input
    drive('{1'b0, 1'b0, 2'd0, 6'd0, -16'sd32768, 32'sd0});
    @(negedge clk);
    chk("R4 min input", out_data, -32'sd13107);
    in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule